// File: doc/BRIEF.md
# EEPROM Page-Write Load Controller

This block is the device-side control logic of a byte-wide electrically erasable memory. It samples the active-low chip-enable, output-enable and write-enable strobes on the system clock and decodes them into read, write, standby and inhibit modes. During a write, the address is taken when the later of the two write strobes falls, and the data when the earlier of them rises. Accepted bytes are collected in a one-page buffer. Each buffered byte has its own valid bit.

Each new byte load restarts a load window. When the window runs out with no new load, the controller raises `busy` and runs a self-timed programming phase. At the end of that phase it copies the valid buffered bytes into a register array that stands in for the nonvolatile cells. Reads return array contents on a data bus that is split into in, out and drive-enable. The load window, the programming time and the glitch filter are all set in clock cycles, so a simulation can use short values.

Top module: `eep_page_ctrl`

## Requirements
- R1: After reset every stored byte reads 0xFF, and `busy`, `page_err` and `dout_en` are low.
- R2: `dout_en` is high exactly when `ce_n` and `oe_n` are both low, and `dout` then shows the stored byte at `addr`. When `dout_en` is low, `dout` is 0.
- R3: A byte load happens only while `ce_n` and `we_n` are low and `oe_n` is high. With `oe_n` low, the same strobes store nothing and start no programming.
- R4: The load address is the value of `addr` on the first clock that sees both `ce_n` and `we_n` low, whichever of them fell last. Later changes of `addr` in the same load have no effect.
- R5: The load data is the value of `din` on the last clock before either `ce_n` or `we_n` returns high. Changes of `din` made together with or after that first rise are not stored.
- R6: A write overlap lasting fewer than `MIN_PULSE_CYC` clocks stores nothing and starts no programming.
- R7: All bytes loaded for one page (page = `addr[16:8]`, offset = `addr[7:0]`) are programmed together. Offsets in that page that were not loaded keep their contents.
- R8: Programming does not start while each new load begins within `LOAD_WIN_CYC` clocks of the previous load start.
- R9: With no further load, `busy` is first seen high `LOAD_WIN_CYC`+2 clocks after the clock edge before the last load start, and it stays high for exactly `PROG_CYC` clocks. The array shows the new bytes only after `busy` falls.
- R10: A load whose page differs from the first buffered byte's page is dropped and raises `page_err` for one clock. Bytes of the original page are still programmed.
- R11: Write strobes while `busy` is high store nothing and do not cause a second programming phase.
- R12: Pages at or above `1 << CELL_PG_W` are not stored and always read 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 17 | Byte address: page in the upper 9 bits, offset in the lower 8 |
| din | input | 8 | Write data from the bus |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dout | output | 8 | Read data, 0 when not driving |
| dout_en | output | 1 | Drive enable for the data bus |
| busy | output | 1 | High during the self-timed programming phase |
| page_err | output | 1 | One-clock pulse when a load for a foreign page is dropped |

## Verification
A wrong state register or window counter shows up on `busy`. It rises too early, within one load window, or too late, more than `LOAD_WIN_CYC`+2 clocks after the last load start, or it stays high for the wrong number of clocks. These effects are visible within one window or one programming phase. A wrong capture edge, a bad buffer index or a stale valid bit shows up only after `busy` falls, when reads return the wrong byte or an untouched offset that has changed. The bench therefore reads back both the loaded offsets and their neighbours. A lost page comparison shows as a missing `page_err` pulse on the clock after the strobes rise, and later as foreign data in the first page.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY,
        MODE_READ,
        MODE_WRITE,
        MODE_INHIBIT
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG
    } ctl_state_e;

endpackage

// File: rtl/eep_strobe_decode.sv
module eep_strobe_decode
    import eep_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int MIN_PULSE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output bus_mode_e         mode,
    output logic              write_act,
    output logic              load_start,
    output logic              load_commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    localparam int CNT_W = $clog2(MIN_PULSE_CYC + 1);

    logic             act_q;
    logic [CNT_W-1:0] width_q;

    // Strobe decode: a high chip enable dominates, a low output enable wins over write enable
    always_comb begin
        if (ce_n)       mode = MODE_STANDBY;
        else if (!oe_n) mode = MODE_READ;
        else if (!we_n) mode = MODE_WRITE;
        else            mode = MODE_INHIBIT;
    end

    assign write_act  = (mode == MODE_WRITE);
    assign load_start = write_act && !act_q;
    // An overlap ending because OE dropped is an abort, not a load
    assign load_commit = act_q && !write_act && (ce_n || we_n)
                         && (width_q >= CNT_W'(MIN_PULSE_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q    <= 1'b0;
            width_q  <= '0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            act_q <= write_act;
            if (load_start) begin
                cap_addr <= addr;
                width_q  <= CNT_W'(1);
            end else if (write_act && (width_q < CNT_W'(MIN_PULSE_CYC))) begin
                width_q <= width_q + CNT_W'(1);
            end
            if (write_act) begin
                cap_data <= din;
            end
        end
    end

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic [OFF_W-1:0]                   wr_off,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               clr,
    output logic [(1<<OFF_W)-1:0][DATA_W-1:0]  bytes,
    output logic [(1<<OFF_W)-1:0]              valid
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes <= '0;
            valid <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (wr) begin
            bytes[wr_off] <= wr_data;
            valid[wr_off] <= 1'b1;
        end
    end

endmodule

// File: rtl/eep_cells.sv
module eep_cells #(
    parameter int DATA_W    = 8,
    parameter int OFF_W     = 8,
    parameter int PG_W      = 9,
    parameter int CELL_PG_W = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [PG_W-1:0]                    rd_page,
    input  logic [OFF_W-1:0]                   rd_off,
    output logic [DATA_W-1:0]                  rd_data,
    input  logic                               commit,
    input  logic [PG_W-1:0]                    commit_pg,
    input  logic [(1<<OFF_W)-1:0][DATA_W-1:0]  bytes,
    input  logic [(1<<OFF_W)-1:0]              valid
);

    localparam int PAGE_SZ = 1 << OFF_W;
    localparam int DEPTH   = (1 << CELL_PG_W) * PAGE_SZ;
    localparam int IDX_W   = CELL_PG_W + OFF_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;
    logic                         rd_hit;
    logic [IDX_W-1:0]             rd_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else if (commit) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((commit_pg == PG_W'(i / PAGE_SZ)) && valid[i % PAGE_SZ]) begin
                    mem_q[i] <= bytes[i % PAGE_SZ];
                end
            end
        end
    end

    assign rd_hit  = ((rd_page >> CELL_PG_W) == '0);
    assign rd_idx  = {rd_page[CELL_PG_W-1:0], rd_off};
    assign rd_data = rd_hit ? mem_q[rd_idx] : '1;

endmodule

// File: rtl/eep_page_ctrl.sv
module eep_page_ctrl
    import eep_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int OFF_W         = 8,
    parameter int CELL_PG_W     = 2,
    parameter int LOAD_WIN_CYC  = 5000,
    parameter int PROG_CYC      = 500000,
    parameter int MIN_PULSE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              busy,
    output logic              page_err
);

    localparam int PG_W    = ADDR_W - OFF_W;
    localparam int PAGE_SZ = 1 << OFF_W;
    localparam int WIN_W   = $clog2(LOAD_WIN_CYC + 1);
    localparam int PRG_W   = $clog2(PROG_CYC + 1);

    bus_mode_e                     mode;
    logic                          write_act, load_start, load_commit;
    logic [ADDR_W-1:0]             cap_addr;
    logic [DATA_W-1:0]             cap_data;
    logic [PG_W-1:0]               cap_page;
    logic [OFF_W-1:0]              cap_off;
    logic [PAGE_SZ-1:0][DATA_W-1:0] pg_bytes;
    logic [PAGE_SZ-1:0]            pg_valid;
    logic [DATA_W-1:0]             rd_data;

    ctl_state_e       state_q, state_d;
    logic [PG_W-1:0]  page_q;
    logic [WIN_W-1:0] win_cnt;
    logic [PRG_W-1:0] prog_cnt;
    logic             err_q;
    logic             accept, mismatch, expire, prog_done;

    eep_strobe_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE_CYC(MIN_PULSE_CYC)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .mode(mode), .write_act(write_act),
        .load_start(load_start), .load_commit(load_commit),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    assign cap_page = cap_addr[ADDR_W-1:OFF_W];
    assign cap_off  = cap_addr[OFF_W-1:0];

    // Byte acceptance and page check
    assign accept    = load_commit && (state_q != ST_PROG)
                       && ((state_q == ST_IDLE) || (cap_page == page_q));
    assign mismatch  = load_commit && (state_q == ST_LOAD) && (cap_page != page_q);
    assign expire    = (state_q == ST_LOAD) && !write_act && !load_commit
                       && (win_cnt == WIN_W'(LOAD_WIN_CYC));
    assign prog_done = (state_q == ST_PROG) && (prog_cnt == PRG_W'(PROG_CYC - 1));

    eep_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .wr(accept), .wr_off(cap_off), .wr_data(cap_data),
        .clr(prog_done), .bytes(pg_bytes), .valid(pg_valid)
    );

    eep_cells #(
        .DATA_W(DATA_W), .OFF_W(OFF_W), .PG_W(PG_W), .CELL_PG_W(CELL_PG_W)
    ) u_cells (
        .clk(clk), .rst_n(rst_n),
        .rd_page(addr[ADDR_W-1:OFF_W]), .rd_off(addr[OFF_W-1:0]), .rd_data(rd_data),
        .commit(prog_done), .commit_pg(page_q), .bytes(pg_bytes), .valid(pg_valid)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_LOAD;
            ST_LOAD: if (expire) state_d = ST_PROG;
            ST_PROG: if (prog_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            page_q   <= '0;
            win_cnt  <= '0;
            prog_cnt <= '0;
            err_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept && (state_q == ST_IDLE)) begin
                page_q <= cap_page;
            end
            if (load_start) begin
                win_cnt <= '0;
            end else if (win_cnt != WIN_W'(LOAD_WIN_CYC)) begin
                win_cnt <= win_cnt + WIN_W'(1);
            end
            prog_cnt <= (state_q == ST_PROG) ? prog_cnt + PRG_W'(1) : '0;
            err_q    <= mismatch;
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q == ST_PROG);
        dout_en  = (mode == MODE_READ);
        dout     = dout_en ? rd_data : '0;
        page_err = err_q;
    end

endmodule

// File: rtl/eep_page_ctrl_chk.sv
module eep_page_ctrl_chk #(
    parameter int LOAD_WIN_CYC = 5000,
    parameter int PROG_CYC     = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic dout_en,
    input logic busy,
    input logic page_err
);

    localparam int SINCE_W = $clog2(LOAD_WIN_CYC + 2);
    localparam int BLEN_W  = $clog2(PROG_CYC + 2);

    logic               wact, wact_q;
    logic [SINCE_W-1:0] since_q;
    logic [BLEN_W-1:0]  blen_q;

    assign wact = !ce_n && !we_n && oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wact_q  <= 1'b0;
            since_q <= '0;
            blen_q  <= '0;
        end else begin
            wact_q <= wact;
            if (wact && !wact_q) since_q <= '0;
            else if (since_q != SINCE_W'(LOAD_WIN_CYC + 1)) since_q <= since_q + SINCE_W'(1);
            if (!busy) blen_q <= '0;
            else if (blen_q != BLEN_W'(PROG_CYC + 1)) blen_q <= blen_q + BLEN_W'(1);
        end
    end

    // R2: bus released whenever either select strobe is high
    a_r2_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> !dout_en);

    // R2: bus driven when both select strobes are low
    a_r2_drive_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |-> dout_en);

    // R8: programming never starts inside the window of the last load start
    a_r8_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (since_q >= SINCE_W'(LOAD_WIN_CYC)));

    // R9: busy lasts exactly the programming time
    a_r9_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (blen_q == BLEN_W'(PROG_CYC)));

    // R10: page errors are only reported while loading
    a_r10_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |-> !busy);

    // R10: the error flag is a single-clock pulse
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        page_err |=> !page_err);

endmodule

bind eep_page_ctrl eep_page_ctrl_chk #(
    .LOAD_WIN_CYC(LOAD_WIN_CYC), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dout_en(dout_en), .busy(busy), .page_err(page_err)
);

// File: tb/sim_eep_page_ctrl.sv
module sim_eep_page_ctrl;

    localparam int WIN  = 40;
    localparam int PRG  = 60;
    localparam int MINP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [7:0]  dout;
    logic        dout_en, busy, page_err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int start_cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    eep_page_ctrl #(
        .LOAD_WIN_CYC(WIN), .PROG_CYC(PRG), .MIN_PULSE_CYC(MINP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .dout(dout), .dout_en(dout_en), .busy(busy), .page_err(page_err)
    );

    function automatic logic [16:0] pa(input int pg, input int off);
        return {9'(pg), 8'(off)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic idle_bus();
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr_byte(input logic [16:0] a, input logic [7:0] d, input int len);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        start_cyc = cyc;
        repeat (len) @(negedge clk);
        idle_bus();
        @(negedge clk);
    endtask

    task automatic rd(input logic [16:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #2 d = dout;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic wait_busy(input logic lvl);
        int n = 0;
        while (busy !== lvl && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_idle();
        wait_busy(1'b1);
        wait_busy(1'b0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 busy", busy, 0);
        chk("R1 page_err", page_err, 0);
        chk("R1 dout_en", dout_en, 0);
        rd(pa(1, 8'h10), d);
        chk("R1 erased", d, 8'hFF);
    endtask

    task automatic t_read_enable();
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1; #2;
        chk("R2 oe high no drive", dout_en, 0);
        chk("R2 dout zero", dout, 0);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b0; #2;
        chk("R2 ce high no drive", dout_en, 0);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = pa(0, 0); #2;
        chk("R2 drive", dout_en, 1);
        chk("R2 data", dout, 8'hFF);
        @(negedge clk);
        idle_bus();
    endtask

    task automatic t_page_write();
        logic [7:0] d;
        int n;
        wr_byte(pa(1, 8'h00), 8'hA1, 4);
        repeat (20) @(negedge clk);
        chk("R8 busy during gap", busy, 0);
        wr_byte(pa(1, 8'h10), 8'hB2, 4);
        repeat (20) @(negedge clk);
        chk("R8 busy during gap", busy, 0);
        wr_byte(pa(1, 8'hFF), 8'hC3, 4);
        wait_busy(1'b1);
        chk("R9 start delay", cyc - start_cyc, WIN + 2);
        rd(pa(1, 8'h10), d);
        chk("R9 old data while busy", d, 8'hFF);
        n = 2;
        while (busy && n < 400) begin
            @(negedge clk);
            n++;
        end
        chk("R9 busy length", n, PRG);
        @(negedge clk);
        rd(pa(1, 8'h00), d); chk("R7 byte 0x00", d, 8'hA1);
        rd(pa(1, 8'h10), d); chk("R7 byte 0x10", d, 8'hB2);
        rd(pa(1, 8'hFF), d); chk("R7 byte 0xFF", d, 8'hC3);
        rd(pa(1, 8'h11), d); chk("R7 untouched", d, 8'hFF);
    endtask

    task automatic t_mismatch();
        logic [7:0] d;
        wr_byte(pa(1, 8'h20), 8'h11, 4);
        chk("R10 no err first", page_err, 0);
        wr_byte(pa(2, 8'h20), 8'h22, 4);
        chk("R10 err pulse", page_err, 1);
        wr_byte(pa(1, 8'h21), 8'h33, 4);
        chk("R10 no err same page", page_err, 0);
        wait_idle();
        rd(pa(1, 8'h20), d); chk("R10 kept 0x20", d, 8'h11);
        rd(pa(1, 8'h21), d); chk("R10 kept 0x21", d, 8'h33);
        rd(pa(2, 8'h20), d); chk("R10 dropped", d, 8'hFF);
    endtask

    task automatic t_addr_latch();
        logic [7:0] d;
        // write-enable falls last
        @(negedge clk);
        addr = pa(2, 5); din = 8'h5E; oe_n = 1'b1; ce_n = 1'b0;
        @(negedge clk); we_n = 1'b0;
        @(negedge clk); addr = pa(2, 6);
        repeat (3) @(negedge clk);
        idle_bus();
        // chip-enable falls last
        @(negedge clk);
        addr = pa(2, 7); din = 8'h7D; we_n = 1'b0;
        @(negedge clk); addr = pa(2, 8); ce_n = 1'b0;
        repeat (4) @(negedge clk);
        idle_bus();
        wait_idle();
        rd(pa(2, 5), d); chk("R4 we-last addr", d, 8'h5E);
        rd(pa(2, 6), d); chk("R4 late addr ignored", d, 8'hFF);
        rd(pa(2, 7), d); chk("R4 early addr ignored", d, 8'hFF);
        rd(pa(2, 8), d); chk("R4 ce-last addr", d, 8'h7D);
    endtask

    task automatic t_data_latch();
        logic [7:0] d;
        @(negedge clk);
        addr = pa(3, 1); din = 8'h5A; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1; din = 8'hC3;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk);
        addr = pa(3, 2); din = 8'h6B; ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1; din = 8'hD4;
        @(negedge clk); we_n = 1'b1;
        wait_idle();
        rd(pa(3, 1), d); chk("R5 we rises first", d, 8'h5A);
        rd(pa(3, 2), d); chk("R5 ce rises first", d, 8'h6B);
    endtask

    task automatic t_oe_block();
        logic [7:0] d;
        int seen = 0;
        @(negedge clk);
        addr = pa(0, 8'h30); din = 8'h44; oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
        repeat (5) @(negedge clk);
        idle_bus();
        repeat (WIN + PRG) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk("R3 no programming", seen, 0);
        rd(pa(0, 8'h30), d); chk("R3 unchanged", d, 8'hFF);
    endtask

    task automatic t_short();
        logic [7:0] d;
        int seen = 0;
        wr_byte(pa(0, 8'h31), 8'h99, MINP - 1);
        repeat (WIN + PRG) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk("R6 no programming", seen, 0);
        rd(pa(0, 8'h31), d); chk("R6 unchanged", d, 8'hFF);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] d;
        int seen = 0;
        wr_byte(pa(0, 0), 8'h77, 4);
        wait_busy(1'b1);
        wr_byte(pa(0, 1), 8'h88, 4);
        wr_byte(pa(3, 9), 8'h5C, 4);
        wait_busy(1'b0);
        repeat (WIN + PRG) begin
            @(negedge clk);
            if (busy) seen = 1;
        end
        chk("R11 no second programming", seen, 0);
        rd(pa(0, 0), d); chk("R11 first byte", d, 8'h77);
        rd(pa(0, 1), d); chk("R11 ignored same page", d, 8'hFF);
        rd(pa(3, 9), d); chk("R11 ignored other page", d, 8'hFF);
    endtask

    task automatic t_out_of_range();
        logic [7:0] d;
        wr_byte(pa(5, 0), 8'h12, 4);
        wait_idle();
        rd(pa(5, 0), d); chk("R12 unmapped page", d, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_enable();
        t_page_write();
        t_mismatch();
        t_addr_latch();
        t_data_latch();
        t_oe_block();
        t_short();
        t_busy_ignore();
        t_out_of_range();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        summary();
    end

endmodule